// File: doc/BRIEF.md
# Configuration Register Reset-Class Controller

This block holds a small file of configuration registers and applies attribute rules to each one. Every register belongs to one of four reset classes, set by parameter. The class decides how the register responds to hard reset, hot reset and function level reset (FLR). The block also decides, for each write, whether the register takes the new value.

Registers of the hardware-initialised class carry a write lock. By default they accept one write and then lock. Two global commands re-lock or release every such register at once. A per-register option decides whether a hard reset leaves the register open for writing. Any register may also hold status bits that clear only where a 1 is written.

The block sits beside a larger configuration space and supplies the register state. Decoding capabilities and giving meaning to the individual registers belong to the surrounding logic.

Top module: `cfg_reset_ctrl`

## Requirements
- R1: While `hrst_n` is low, and on the first sample after it rises, every register reads its INIT_VAL, whatever its class, and `wr_ack` is 0. Register i lives at address i and appears on `reg_q[i*W +: W]`.
- R2: A register of class code 0 (plain) returns to its INIT_VAL in the cycle after either `hot_rst` or `flr` is high.
- R3: A register of class code 1 (FLR-exempt) keeps its value through `flr`, and returns to INIT_VAL in the cycle after `hot_rst`.
- R4: A register of class code 2 (sticky) keeps its value through both `hot_rst` and `flr`. Class code 3 (hardware-initialised) does the same, and its lock state is also unaffected.
- R5: If a write and a reset that affects the target register arrive in the same cycle, the reset wins. If the reset does not affect that register, the write takes effect.
- R6: Bits set in a register's W1C_MASK clear where the written data is 1 and hold where it is 0. All other bits take the written value.
- R7: A class 3 register with its ONCE_ONLY bit set locks after its first accepted write. Later writes to it are dropped.
- R8: After a hard reset, a class 3 register is locked unless its WR_AFTER_HRST bit is set. If that bit is set, the register is unlocked and its write-once flag is re-armed.
- R9: `unlock_all` opens every class 3 register and `lock_all` locks every one. If both are high together, `lock_all` wins. A write in the same cycle is judged against the lock state held before that edge.
- R10: `wr_ack` is high in the cycle after each cycle with `wr_en` high. This holds for dropped writes and for addresses at or beyond NREG.
- R11: A class 3 register with its ONCE_ONLY bit clear stays writable, write after write, until `lock_all`.
- R12: A write to an address at or beyond NREG changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Asynchronous active-low hard reset |
| hot_rst | input | 1 | Hot reset, one cycle per event |
| flr | input | 1 | Function level reset, one cycle per event |
| lock_all | input | 1 | Lock every hardware-initialised register |
| unlock_all | input | 1 | Unlock every hardware-initialised register |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Register index for the write |
| wr_data | input | W | Write data |
| wr_ack | output | 1 | Write acknowledge, one cycle after the strobe |
| reg_q | output | NREG*W | All register values, register i at bits i*W upward |

## Verification
The bench builds the block with six 16-bit registers: one plain register carrying W1C bits in its upper byte, one FLR-exempt register, one sticky register, and three hardware-initialised registers. The three hardware-initialised registers take the three useful combinations of the hard-reset and write-once options. With this set-up one run can cover every reset class against every reset kind. It also brings within reach the locked-after-hard-reset, write-once and freely-writable lock variants, W1C clearing next to ordinary bits, and out-of-range addresses. A second hard reset in mid-run shows that sticky contents are cleared and that the write-once flag is re-armed.

// File: rtl/cfgrc_pkg.sv
package cfgrc_pkg;
   typedef enum logic [1:0] {
      RC_PLAIN  = 2'd0,
      RC_NOFLR  = 2'd1,
      RC_STICKY = 2'd2,
      RC_HWINIT = 2'd3
   } rc_e;
endpackage

// File: rtl/cfg_hw_lock.sv
module cfg_hw_lock #(
   parameter bit AFTER_HRST = 1'b0,
   parameter bit ONCE_ONLY  = 1'b1
) (
   input  logic clk,
   input  logic hrst_n,
   input  logic lock_all,
   input  logic unlock_all,
   input  logic wr_hit,
   output logic locked
);
   always_ff @(posedge clk or negedge hrst_n) begin
      if (!hrst_n)                             locked <= !AFTER_HRST;
      else if (lock_all)                       locked <= 1'b1;
      else if (unlock_all)                     locked <= 1'b0;
      else if (wr_hit && !locked && ONCE_ONLY) locked <= 1'b1;
   end

   assert_lock_wins_R9: assert property (@(posedge clk) disable iff (!hrst_n)
      lock_all |=> locked);
   assert_unlock_R9: assert property (@(posedge clk) disable iff (!hrst_n)
      unlock_all && !lock_all |=> !locked);

   generate
      if (ONCE_ONLY) begin : g_once
         assert_once_locks_R7: assert property (@(posedge clk) disable iff (!hrst_n)
            wr_hit && !locked && !unlock_all |=> locked);
      end else begin : g_free
         assert_stays_open_R11: assert property (@(posedge clk) disable iff (!hrst_n)
            !locked && !lock_all |=> !locked);
      end
   endgenerate
endmodule

// File: rtl/cfg_reg_slot.sv
module cfg_reg_slot #(
   parameter int              W          = 16,
   parameter cfgrc_pkg::rc_e  CLS        = cfgrc_pkg::RC_PLAIN,
   parameter logic [W-1:0]    INIT       = '0,
   parameter logic [W-1:0]    W1C        = '0,
   parameter bit              AFTER_HRST = 1'b0,
   parameter bit              ONCE_ONLY  = 1'b1
) (
   input  logic         clk,
   input  logic         hrst_n,
   input  logic         hot_rst,
   input  logic         flr,
   input  logic         lock_all,
   input  logic         unlock_all,
   input  logic         wr_hit,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] q
);
   localparam bit CLR_ON_FLR = (CLS == cfgrc_pkg::RC_PLAIN);
   localparam bit CLR_ON_HOT = (CLS == cfgrc_pkg::RC_PLAIN) || (CLS == cfgrc_pkg::RC_NOFLR);
   localparam bit KEEPS_ALL  = (CLS == cfgrc_pkg::RC_STICKY) || (CLS == cfgrc_pkg::RC_HWINIT);

   logic rst_hit;
   logic wr_ok;
   logic [W-1:0] merged;

   assign rst_hit = (CLR_ON_FLR && flr) || (CLR_ON_HOT && hot_rst);
   assign merged  = (wr_data & ~W1C) | (q & ~wr_data & W1C);

   generate
      if (CLS == cfgrc_pkg::RC_HWINIT) begin : g_hw
         logic locked;
         cfg_hw_lock #(.AFTER_HRST(AFTER_HRST), .ONCE_ONLY(ONCE_ONLY)) u_lock (
            .clk(clk), .hrst_n(hrst_n), .lock_all(lock_all),
            .unlock_all(unlock_all), .wr_hit(wr_hit), .locked(locked));
         assign wr_ok = !locked;

         assert_locked_drop_R7: assert property (@(posedge clk) disable iff (!hrst_n)
            locked && wr_hit |=> $stable(q));
      end else begin : g_open
         assign wr_ok = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge hrst_n) begin
      if (!hrst_n)              q <= INIT;
      else if (rst_hit)         q <= INIT;
      else if (wr_hit && wr_ok) q <= merged;
   end

   generate
      if (KEEPS_ALL) begin : g_chk_keep
         assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!hrst_n)
            (hot_rst || flr) && !wr_hit |=> $stable(q));
      end
      if (CLS == cfgrc_pkg::RC_NOFLR) begin : g_chk_noflr
         assert_flr_hold_R3: assert property (@(posedge clk) disable iff (!hrst_n)
            flr && !hot_rst && !wr_hit |=> $stable(q));
      end
      if (CLR_ON_HOT) begin : g_chk_hot
         assert_hot_init_R5: assert property (@(posedge clk) disable iff (!hrst_n)
            hot_rst |=> q == INIT);
      end
      if (CLR_ON_FLR) begin : g_chk_flr
         assert_flr_init_R2: assert property (@(posedge clk) disable iff (!hrst_n)
            flr |=> q == INIT);
      end
      if (W1C != '0) begin : g_chk_w1c
         assert_w1c_no_set_R6: assert property (@(posedge clk) disable iff (!hrst_n)
            wr_hit && !rst_hit |=> (q & W1C & ~$past(q)) == '0);
      end
   endgenerate
endmodule

// File: rtl/cfg_reset_ctrl.sv
module cfg_reset_ctrl #(
   parameter int                NREG          = 4,
   parameter int                W             = 16,
   parameter logic [2*NREG-1:0] REG_CLASS     = 8'b11_10_01_00,
   parameter logic [NREG*W-1:0] INIT_VAL      = '0,
   parameter logic [NREG*W-1:0] W1C_MASK      = '0,
   parameter logic [NREG-1:0]   WR_AFTER_HRST = '0,
   parameter logic [NREG-1:0]   ONCE_ONLY     = '1,
   localparam int               AW            = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              hrst_n,
   input  logic              hot_rst,
   input  logic              flr,
   input  logic              lock_all,
   input  logic              unlock_all,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [W-1:0]      wr_data,
   output logic              wr_ack,
   output logic [NREG*W-1:0] reg_q
);
   generate
      if (NREG < 1) begin : g_bad_nreg
         $error("cfg_reset_ctrl: NREG must be at least 1");
      end
      if (W < 1) begin : g_bad_w
         $error("cfg_reset_ctrl: W must be at least 1");
      end
   endgenerate

   logic [NREG-1:0] wr_hit;

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_slot
         assign wr_hit[i] = wr_en && (wr_addr == AW'(i));
         cfg_reg_slot #(
            .W(W),
            .CLS(cfgrc_pkg::rc_e'(REG_CLASS[2*i +: 2])),
            .INIT(INIT_VAL[i*W +: W]),
            .W1C(W1C_MASK[i*W +: W]),
            .AFTER_HRST(WR_AFTER_HRST[i]),
            .ONCE_ONLY(ONCE_ONLY[i])
         ) u_slot (
            .clk(clk), .hrst_n(hrst_n), .hot_rst(hot_rst), .flr(flr),
            .lock_all(lock_all), .unlock_all(unlock_all),
            .wr_hit(wr_hit[i]), .wr_data(wr_data), .q(reg_q[i*W +: W]));
      end
   endgenerate

   always_ff @(posedge clk or negedge hrst_n) begin
      if (!hrst_n) wr_ack <= 1'b0;
      else         wr_ack <= wr_en;
   end

   assert_ack_follows_R10: assert property (@(posedge clk) disable iff (!hrst_n)
      wr_en |=> wr_ack);
   assert_ack_only_R10: assert property (@(posedge clk) disable iff (!hrst_n)
      !wr_en |=> !wr_ack);
   assert_oor_quiet_R12: assert property (@(posedge clk) disable iff (!hrst_n)
      wr_en && (int'(wr_addr) >= NREG) && !hot_rst && !flr |=> $stable(reg_q));
endmodule

// File: tb/cfg_reset_ctrl_test.sv
`timescale 1ns/1ps
module cfg_reset_ctrl_test;
   localparam int NREG = 6;
   localparam int W    = 16;
   localparam int AW   = 3;

   logic clk = 1'b0;
   logic hrst_n = 1'b0;
   logic hot_rst = 1'b0, flr = 1'b0, lock_all = 1'b0, unlock_all = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic wr_ack;
   logic [NREG*W-1:0] reg_q;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cfg_reset_ctrl #(
      .NREG(NREG), .W(W),
      .REG_CLASS(12'b11_11_11_10_01_00),
      .INIT_VAL({16'h5555, 16'h4444, 16'h3333, 16'h2222, 16'h1111, 16'hA5F0}),
      .W1C_MASK({16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'hFF00}),
      .WR_AFTER_HRST(6'b110000),
      .ONCE_ONLY(6'b011000)
   ) uut (
      .clk(clk), .hrst_n(hrst_n), .hot_rst(hot_rst), .flr(flr),
      .lock_all(lock_all), .unlock_all(unlock_all), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack), .reg_q(reg_q));

   // {addr, data, expected value of that register, requirement number}
   localparam logic [38:0] VEC [9] = '{
      {3'd0, 16'h0F3C, 16'hA03C, 4'd6},
      {3'd0, 16'hFF00, 16'h0000, 4'd6},
      {3'd1, 16'hBEEF, 16'hBEEF, 4'd6},
      {3'd2, 16'hCAFE, 16'hCAFE, 4'd6},
      {3'd3, 16'h1234, 16'h3333, 4'd8},
      {3'd4, 16'h4321, 16'h4321, 4'd8},
      {3'd4, 16'h9999, 16'h4321, 4'd7},
      {3'd5, 16'h7777, 16'h7777, 4'd11},
      {3'd5, 16'h8888, 16'h8888, 4'd11}
   };

   function automatic logic [W-1:0] rq(input int idx);
      return reg_q[idx*W +: W];
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [W-1:0] d, input logic h, input logic f);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; hot_rst = h; flr = f;
      @(negedge clk);
      wr_en = 1'b0; hot_rst = 1'b0; flr = 1'b0;
   endtask

   task automatic pulse(input logic h, input logic f, input logic lk, input logic ul);
      @(negedge clk);
      hot_rst = h; flr = f; lock_all = lk; unlock_all = ul;
      @(negedge clk);
      hot_rst = 1'b0; flr = 1'b0; lock_all = 1'b0; unlock_all = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #200000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: values held during hard reset
      chk("R1", rq(2), 16'h2222);
      chk("R1", {15'd0, wr_ack}, 16'd0);
      hrst_n = 1'b1;
      @(negedge clk);
      chk("R1", rq(0), 16'hA5F0);
      chk("R1", rq(3), 16'h3333);
      chk("R1", rq(5), 16'h5555);

      for (int k = 0; k < 9; k++) begin
         wr(int'(VEC[k][38:36]), VEC[k][35:20], 1'b0, 1'b0);
         chk($sformatf("R%0d table %0d", VEC[k][3:0], k), rq(int'(VEC[k][38:36])), VEC[k][19:4]);
         chk("R10 ack", {15'd0, wr_ack}, 16'd1);
      end

      // R12 and R10: out-of-range address
      wr(7, 16'hFFFF, 1'b0, 1'b0);
      chk("R10 ack oor", {15'd0, wr_ack}, 16'd1);
      chk("R12", rq(0), 16'h0000);
      chk("R12", rq(1), 16'hBEEF);
      chk("R12", rq(5), 16'h8888);
      @(negedge clk);
      chk("R10 idle", {15'd0, wr_ack}, 16'd0);

      // FLR: R2, R3, R4
      wr(0, 16'h0055, 1'b0, 1'b0);
      chk("R6", rq(0), 16'h0055);
      pulse(1'b0, 1'b1, 1'b0, 1'b0);
      chk("R2 flr", rq(0), 16'hA5F0);
      chk("R3 flr", rq(1), 16'hBEEF);
      chk("R4 flr", rq(2), 16'hCAFE);
      chk("R4 flr hw", rq(4), 16'h4321);

      // hot reset: R2, R3, R4
      wr(0, 16'h0011, 1'b0, 1'b0);
      chk("R6", rq(0), 16'hA511);
      pulse(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R2 hot", rq(0), 16'hA5F0);
      chk("R3 hot", rq(1), 16'h1111);
      chk("R4 hot", rq(2), 16'hCAFE);
      chk("R4 hot hw", rq(5), 16'h8888);

      // R5: write collides with reset
      wr(1, 16'h2468, 1'b0, 1'b1);
      chk("R5 noflr keeps write", rq(1), 16'h2468);
      wr(0, 16'h0000, 1'b0, 1'b1);
      chk("R5 flr wins", rq(0), 16'hA5F0);
      wr(1, 16'h1357, 1'b1, 1'b0);
      chk("R5 hot wins", rq(1), 16'h1111);
      wr(2, 16'h0BAD, 1'b1, 1'b1);
      chk("R5 sticky write", rq(2), 16'h0BAD);

      // R9: global lock and unlock
      pulse(1'b0, 1'b0, 1'b0, 1'b1);
      wr(3, 16'hABCD, 1'b0, 1'b0);
      chk("R9 unlocked", rq(3), 16'hABCD);
      wr(3, 16'h0001, 1'b0, 1'b0);
      chk("R7 relocked", rq(3), 16'hABCD);
      pulse(1'b0, 1'b0, 1'b1, 1'b1);
      wr(4, 16'h5A5A, 1'b0, 1'b0);
      chk("R9 lock wins", rq(4), 16'h4321);
      wr(5, 16'h1357, 1'b0, 1'b0);
      chk("R9 lock free reg", rq(5), 16'h8888);
      pulse(1'b1, 1'b1, 1'b0, 1'b0);
      wr(5, 16'h2222, 1'b0, 1'b0);
      chk("R4 lock kept", rq(5), 16'h8888);
      pulse(1'b0, 1'b0, 1'b0, 1'b1);
      wr(5, 16'h1357, 1'b0, 1'b0);
      chk("R11", rq(5), 16'h1357);
      wr(5, 16'h2468, 1'b0, 1'b0);
      chk("R11", rq(5), 16'h2468);

      // R1 and R8: second hard reset
      @(negedge clk);
      hrst_n = 1'b0;
      @(negedge clk);
      chk("R1 sticky cleared", rq(2), 16'h2222);
      chk("R1 hw cleared", rq(3), 16'h3333);
      hrst_n = 1'b1;
      wr(3, 16'h0F0F, 1'b0, 1'b0);
      chk("R8 locked", rq(3), 16'h3333);
      wr(4, 16'h0F0F, 1'b0, 1'b0);
      chk("R8 rearmed", rq(4), 16'h0F0F);
      wr(4, 16'hF0F0, 1'b0, 1'b0);
      chk("R7 after rearm", rq(4), 16'h0F0F);

      finish_run();
   end
endmodule